// File: doc/BRIEF.md
# Bulk-Bitwise Row Compute Array

A cycle-level, synthesizable model of a small memory subarray that computes on whole rows in place. Every row is a wide bit vector. A command port starts one row-granular operation at a time. An activate reads a row onto the bitlines and writes it back. A copy moves one row into another. A triple activation drives the bitwise majority of three compute rows back into all three of them. A negation transfer writes the complement of a source row into a dual-contact row.

Pre-loading one of the three majority operands with all zeros gives a bitwise AND of the other two. Pre-loading it with all ones gives an OR. Between commands the sense path returns to a precharged, neutral state. A host port reads and writes whole rows while no command is running, and is refused otherwise.

With the default parameters there are 16 rows of 32 bits. The rows split into three ranges: data rows 0 to 9, dual-contact rows 10 and 11, and compute rows 12 to 15. The ranges follow from the parameters as compute rows = the top `NUM_COMPUTE` rows and dual-contact rows = the `NUM_DCC` rows directly below them.

Top module: `row_compute_array`

## Requirements
- R1: After reset every row reads as zero, and `busy`, `done`, `cmdErr` and `senseOut` are low.
- R2: A command is accepted on a clock edge where `cmdValid` is high and `busy` is low. `busy` then stays high for four cycles, and `done` pulses high for exactly the last of them. `cmdValid` while `busy` is high is ignored.
- R3: Opcode 2 (triple activation) on three compute rows writes the bitwise majority of their old contents into all three rows.
- R4: In a triple activation, a third operand row of all zeros leaves the AND of the other two rows, and one of all ones leaves their OR.
- R5: A triple activation that names any row outside the compute range raises `cmdErr` together with `done`, and no row changes.
- R6: Opcode 3 (negation) writes the complement of row A into row B when B is a dual-contact row, leaving row A unchanged. If B is not a dual-contact row, `cmdErr` is raised and no row changes.
- R7: Opcode 1 (copy) writes the whole contents of row A into row B and leaves row A unchanged.
- R8: Opcode 0 (activate) leaves row A unchanged and shows its contents on `senseOut` in the `done` cycle.
- R9: While `busy` is high, `hostGrant` is low, `hostRdata` is zero, and host writes have no effect on any row.
- R10: Whenever `busy` is low, the sense path is precharged and `senseOut` reads zero. During a command, `senseOut` carries the sensed row (the majority, for opcode 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | Command request |
| cmdOp | input | 2 | Opcode: 0 activate, 1 copy, 2 majority, 3 negation |
| cmdRowA | input | ROW_AW | First row (source) |
| cmdRowB | input | ROW_AW | Second row (destination for copy and negation) |
| cmdRowC | input | ROW_AW | Third row (majority only) |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| cmdErr | output | 1 | Command rejected; valid with done |
| senseOut | output | ROW_W | Sensed bitline value |
| hostEn | input | 1 | Host access request |
| hostWe | input | 1 | Host write (with hostEn) |
| hostAddr | input | ROW_AW | Host row index |
| hostWdata | input | ROW_W | Host write row |
| hostGrant | output | 1 | Host access accepted this cycle |
| hostRdata | output | ROW_W | Host read row (zero when not granted) |

## Verification
The hardest situation to reach from the ports is a host access, or a second command, that lands in the middle of a running command. The bench drives both on the cycle right after acceptance. It then proves through ordinary host reads afterwards that neither left a trace. The AND and OR forms of the majority are reached by first loading a compute row with a constant through the host port. Rejected commands are checked by reading every operand row back.

// File: rtl/rca_pkg.sv
package rca_pkg;
  typedef enum logic [1:0] {
    OP_ACT  = 2'd0,
    OP_COPY = 2'd1,
    OP_MAJ  = 2'd2,
    OP_NOT  = 2'd3
  } rcaOp_e;

  typedef struct packed {
    logic   latch;
    logic   commit;
    logic   precharge;
    rcaOp_e op;
  } rcaStrobe_t;
endpackage

// File: rtl/rca_ctrl.sv
module rca_ctrl
  import rca_pkg::*;
#(
  parameter int NUM_ROWS    = 16,
  parameter int NUM_COMPUTE = 4,
  parameter int NUM_DCC     = 2,
  parameter int ROW_AW      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [ROW_AW-1:0] cmdRowA,
  input  logic [ROW_AW-1:0] cmdRowB,
  input  logic [ROW_AW-1:0] cmdRowC,
  output logic              busy,
  output logic              done,
  output logic              cmdErr,
  output rcaStrobe_t        strb,
  output logic [ROW_AW-1:0] rowA,
  output logic [ROW_AW-1:0] rowB,
  output logic [ROW_AW-1:0] rowC
);
  localparam int COMPUTE_BASE = NUM_ROWS - NUM_COMPUTE;
  localparam int DCC_BASE     = COMPUTE_BASE - NUM_DCC;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ACT, ST_SENSE, ST_RESTORE, ST_PRE
  } state_e;

  state_e state;
  rcaOp_e opReg;
  logic   errReg;
  logic   accept;
  logic   badCmd;

  function automatic logic inCompute(input logic [ROW_AW-1:0] r);
    return (int'(r) >= COMPUTE_BASE) && (int'(r) < NUM_ROWS);
  endfunction

  function automatic logic inDcc(input logic [ROW_AW-1:0] r);
    return (int'(r) >= DCC_BASE) && (int'(r) < COMPUTE_BASE);
  endfunction

  function automatic logic inRange(input logic [ROW_AW-1:0] r);
    return int'(r) < NUM_ROWS;
  endfunction

  assign accept = cmdValid && (state == ST_IDLE);

  always_comb begin
    unique case (rcaOp_e'(cmdOp))
      OP_ACT:  badCmd = !inRange(cmdRowA);
      OP_COPY: badCmd = !inRange(cmdRowA) || !inRange(cmdRowB);
      OP_MAJ:  badCmd = !inCompute(cmdRowA) || !inCompute(cmdRowB) || !inCompute(cmdRowC);
      OP_NOT:  badCmd = !inRange(cmdRowA) || !inDcc(cmdRowB);
      default: badCmd = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      opReg  <= OP_ACT;
      errReg <= 1'b0;
      rowA   <= '0;
      rowB   <= '0;
      rowC   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          state  <= ST_ACT;
          opReg  <= rcaOp_e'(cmdOp);
          errReg <= badCmd;
          rowA   <= cmdRowA;
          rowB   <= cmdRowB;
          rowC   <= cmdRowC;
        end
        ST_ACT:     state <= ST_SENSE;
        ST_SENSE:   state <= ST_RESTORE;
        ST_RESTORE: state <= ST_PRE;
        ST_PRE:     state <= ST_IDLE;
        default:    state <= ST_IDLE;
      endcase
    end
  end

  assign busy   = (state != ST_IDLE);
  assign done   = (state == ST_PRE);
  assign cmdErr = (state == ST_PRE) && errReg;

  always_comb begin
    strb.latch     = (state == ST_ACT) && !errReg;
    strb.commit    = (state == ST_RESTORE) && !errReg;
    strb.precharge = (state == ST_PRE);
    strb.op        = opReg;
  end

  AST_ACCEPT_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !busy) |=> busy) else $error("accept"); // R2
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!busy && !done)) else $error("done"); // R2
  AST_ERR_ONLY_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    cmdErr |-> done) else $error("err"); // R5
  AST_ROWS_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> ($stable(rowA) && $stable(rowB) && $stable(rowC))) else $error("rows"); // R2
endmodule

// File: rtl/rca_datapath.sv
module rca_datapath
  import rca_pkg::*;
#(
  parameter int NUM_ROWS = 16,
  parameter int ROW_W    = 32,
  parameter int ROW_AW   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  rcaStrobe_t        strb,
  input  logic              busy,
  input  logic [ROW_AW-1:0] rowA,
  input  logic [ROW_AW-1:0] rowB,
  input  logic [ROW_AW-1:0] rowC,
  output logic [ROW_W-1:0]  senseOut,
  input  logic              hostEn,
  input  logic              hostWe,
  input  logic [ROW_AW-1:0] hostAddr,
  input  logic [ROW_W-1:0]  hostWdata,
  output logic              hostGrant,
  output logic [ROW_W-1:0]  hostRdata
);
  logic [NUM_ROWS-1:0][ROW_W-1:0] rows;
  logic [ROW_W-1:0] bitline;
  logic [ROW_W-1:0] majVal;
  logic [ROW_W-1:0] opA, opB, opC;
  logic [ROW_W-1:0] wrVal;

  assign opA    = rows[rowA];
  assign opB    = rows[rowB];
  assign opC    = rows[rowC];
  assign majVal = (opA & opB) | (opB & opC) | (opA & opC);

  // Bitline: precharged (zero) outside a command, sensed value inside.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitline <= '0;
    end else if (strb.latch) begin
      bitline <= (strb.op == OP_MAJ) ? majVal : opA;
    end else if (strb.precharge) begin
      bitline <= '0;
    end
  end

  assign wrVal     = (strb.op == OP_NOT) ? ~bitline : bitline;
  assign hostGrant = hostEn && !busy;
  assign hostRdata = hostGrant ? rows[hostAddr] : '0;
  assign senseOut  = bitline;

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
    logic hostHit;
    logic cmdHit;
    assign hostHit = hostGrant && hostWe && (hostAddr == ROW_AW'(r));
    always_comb begin
      unique case (strb.op)
        OP_ACT:  cmdHit = (rowA == ROW_AW'(r));
        OP_COPY: cmdHit = (rowB == ROW_AW'(r));
        OP_NOT:  cmdHit = (rowB == ROW_AW'(r));
        OP_MAJ:  cmdHit = (rowA == ROW_AW'(r)) || (rowB == ROW_AW'(r)) || (rowC == ROW_AW'(r));
        default: cmdHit = 1'b0;
      endcase
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rows[r] <= '0;
      end else if (strb.commit && cmdHit) begin
        rows[r] <= wrVal;
      end else if (hostHit) begin
        rows[r] <= hostWdata;
      end
    end
  end

  AST_BUSY_ROWS_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strb.commit) |=> $stable(rows)) else $error("frozen"); // R9
  AST_IDLE_PRECHARGED: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (senseOut == '0)) else $error("precharge"); // R10
  AST_MAJ_AGREE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && strb.op == OP_MAJ) |=> ((rows[rowA] == rows[rowB]) && (rows[rowB] == rows[rowC]))) else $error("maj"); // R3
  AST_NOT_COMPLEMENT: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && strb.op == OP_NOT) |=> (rows[rowB] == ~senseOut)) else $error("not"); // R6
endmodule

// File: rtl/row_compute_array.sv
module row_compute_array
  import rca_pkg::*;
#(
  parameter int NUM_ROWS    = 16,
  parameter int ROW_W       = 32,
  parameter int NUM_COMPUTE = 4,
  parameter int NUM_DCC     = 2,
  parameter int ROW_AW      = $clog2(NUM_ROWS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [ROW_AW-1:0] cmdRowA,
  input  logic [ROW_AW-1:0] cmdRowB,
  input  logic [ROW_AW-1:0] cmdRowC,
  output logic              busy,
  output logic              done,
  output logic              cmdErr,
  output logic [ROW_W-1:0]  senseOut,
  input  logic              hostEn,
  input  logic              hostWe,
  input  logic [ROW_AW-1:0] hostAddr,
  input  logic [ROW_W-1:0]  hostWdata,
  output logic              hostGrant,
  output logic [ROW_W-1:0]  hostRdata
);
  rcaStrobe_t        strb;
  logic [ROW_AW-1:0] rowA, rowB, rowC;

  rca_ctrl #(
    .NUM_ROWS(NUM_ROWS), .NUM_COMPUTE(NUM_COMPUTE), .NUM_DCC(NUM_DCC), .ROW_AW(ROW_AW)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdRowA(cmdRowA), .cmdRowB(cmdRowB), .cmdRowC(cmdRowC),
    .busy(busy), .done(done), .cmdErr(cmdErr), .strb(strb),
    .rowA(rowA), .rowB(rowB), .rowC(rowC)
  );

  rca_datapath #(
    .NUM_ROWS(NUM_ROWS), .ROW_W(ROW_W), .ROW_AW(ROW_AW)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .busy(busy),
    .rowA(rowA), .rowB(rowB), .rowC(rowC), .senseOut(senseOut),
    .hostEn(hostEn), .hostWe(hostWe), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .hostGrant(hostGrant), .hostRdata(hostRdata)
  );
endmodule

// File: tb/row_compute_array_tb_top.sv
module row_compute_array_tb_top;
  localparam int W  = 32;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [1:0] cmdOp = '0;
  logic [AW-1:0] cmdRowA = '0, cmdRowB = '0, cmdRowC = '0;
  logic busy, done, cmdErr, hostGrant;
  logic [W-1:0] senseOut, hostRdata;
  logic hostEn = 1'b0, hostWe = 1'b0;
  logic [AW-1:0] hostAddr = '0;
  logic [W-1:0] hostWdata = '0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  row_compute_array dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdRowA(cmdRowA), .cmdRowB(cmdRowB), .cmdRowC(cmdRowC),
    .busy(busy), .done(done), .cmdErr(cmdErr), .senseOut(senseOut),
    .hostEn(hostEn), .hostWe(hostWe), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .hostGrant(hostGrant), .hostRdata(hostRdata)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input int a, input logic [W-1:0] d);
    @(negedge clk);
    hostEn = 1'b1; hostWe = 1'b1; hostAddr = AW'(a); hostWdata = d;
    @(negedge clk);
    hostEn = 1'b0; hostWe = 1'b0;
  endtask

  task automatic hostRead(input int a, output logic [W-1:0] d);
    @(negedge clk);
    hostEn = 1'b1; hostWe = 1'b0; hostAddr = AW'(a);
    #1;
    d = hostRdata;
    hostEn = 1'b0;
  endtask

  task automatic expectRow(input string req, input int a, input logic [W-1:0] exp);
    logic [W-1:0] d;
    hostRead(a, d);
    chk(req, d, exp);
  endtask

  // Runs one command; poke drives a second command and a host write in the first busy cycle.
  task automatic runCmd(input logic [1:0] op, input int a, input int b, input int c,
                        input bit poke, output logic e, output logic [W-1:0] s);
    int n;
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op;
    cmdRowA = AW'(a); cmdRowB = AW'(b); cmdRowC = AW'(c);
    @(negedge clk);
    cmdValid = 1'b0;
    chk("R2 busy after accept", W'(busy), W'(1));
    if (poke) begin
      cmdValid = 1'b1; cmdOp = 2'd1; cmdRowA = AW'(0); cmdRowB = AW'(1);
      hostEn = 1'b1; hostWe = 1'b1; hostAddr = AW'(0); hostWdata = 32'hDEAD_BEEF;
      #1;
      chk("R9 grant low while busy", W'(hostGrant), W'(0));
      chk("R9 rdata zero while busy", hostRdata, '0);
    end
    n = 1;
    while (!done && n < 20) begin
      @(negedge clk);
      cmdValid = 1'b0; hostEn = 1'b0; hostWe = 1'b0;
      n++;
    end
    chk("R2 done latency", W'(n), W'(4));
    e = cmdErr;
    s = senseOut;
    @(negedge clk);
    chk("R2 busy cleared", W'(busy), W'(0));
    chk("R2 done one cycle", W'(done), W'(0));
    chk("R10 precharged after command", senseOut, '0);
  endtask

  task automatic testReset();
    chk("R1 busy", W'(busy), W'(0));
    chk("R1 done", W'(done), W'(0));
    chk("R1 err", W'(cmdErr), W'(0));
    chk("R1 sense", senseOut, '0);
    for (int r = 0; r < 16; r++) expectRow("R1 row zero", r, '0);
  endtask

  task automatic testActCopy();
    logic e; logic [W-1:0] s;
    hostWrite(3, 32'h1234_5678);
    runCmd(2'd0, 3, 0, 0, 1'b0, e, s);
    chk("R8 sense shows row", s, 32'h1234_5678);
    chk("R8 no err", W'(e), '0);
    expectRow("R8 row unchanged", 3, 32'h1234_5678);
    runCmd(2'd1, 3, 5, 0, 1'b0, e, s);
    chk("R10 sense during copy", s, 32'h1234_5678);
    expectRow("R7 copy dst", 5, 32'h1234_5678);
    expectRow("R7 copy src", 3, 32'h1234_5678);
  endtask

  task automatic testMaj();
    logic e; logic [W-1:0] s;
    logic [W-1:0] a, b, c, m;
    a = 32'hF0F0_1234; b = 32'hCCCC_5678; c = 32'hAAAA_9ABC;
    m = (a & b) | (b & c) | (a & c);
    hostWrite(12, a); hostWrite(13, b); hostWrite(14, c);
    runCmd(2'd2, 12, 13, 14, 1'b0, e, s);
    chk("R3 no err", W'(e), '0);
    chk("R10 sense carries majority", s, m);
    expectRow("R3 row12", 12, m);
    expectRow("R3 row13", 13, m);
    expectRow("R3 row14", 14, m);
  endtask

  task automatic testAndOr();
    logic e; logic [W-1:0] s;
    logic [W-1:0] a, b;
    a = 32'h0FF0_A5A5; b = 32'h3C3C_FF00;
    hostWrite(12, a); hostWrite(13, b); hostWrite(15, '0);
    runCmd(2'd2, 12, 13, 15, 1'b0, e, s);
    expectRow("R4 and result", 12, a & b);
    expectRow("R4 and in control row", 15, a & b);
    hostWrite(12, a); hostWrite(13, b); hostWrite(14, '1);
    runCmd(2'd2, 14, 12, 13, 1'b0, e, s);
    expectRow("R4 or result", 13, a | b);
  endtask

  task automatic testBadMaj();
    logic e; logic [W-1:0] s;
    hostWrite(3, 32'h5555_0000); hostWrite(12, 32'h1111_1111); hostWrite(13, 32'h2222_2222);
    runCmd(2'd2, 12, 3, 13, 1'b0, e, s);
    chk("R5 err raised", W'(e), W'(1));
    expectRow("R5 data row kept", 3, 32'h5555_0000);
    expectRow("R5 row12 kept", 12, 32'h1111_1111);
    expectRow("R5 row13 kept", 13, 32'h2222_2222);
  endtask

  task automatic testNot();
    logic e; logic [W-1:0] s;
    hostWrite(4, 32'h00FF_1357); hostWrite(10, '0); hostWrite(2, 32'h7777_7777);
    runCmd(2'd3, 4, 10, 0, 1'b0, e, s);
    chk("R6 no err", W'(e), '0);
    expectRow("R6 dcc gets complement", 10, ~32'h00FF_1357);
    expectRow("R6 src unchanged", 4, 32'h00FF_1357);
    runCmd(2'd3, 4, 2, 0, 1'b0, e, s);
    chk("R6 err on non-dcc dst", W'(e), W'(1));
    expectRow("R6 rejected dst kept", 2, 32'h7777_7777);
  endtask

  task automatic testBusyRefusal();
    logic e; logic [W-1:0] s;
    hostWrite(0, 32'h0000_AAAA); hostWrite(1, 32'h0000_BBBB); hostWrite(6, 32'h6666_0000);
    runCmd(2'd0, 6, 0, 0, 1'b1, e, s);
    expectRow("R9 host write ignored", 0, 32'h0000_AAAA);
    expectRow("R2 second command ignored", 1, 32'h0000_BBBB);
    @(negedge clk);
    chk("R2 no extra command", W'(busy), W'(0));
  endtask

  initial begin : watchdog
    while (cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL watchdog actual=%0d expected<20000", cycles);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testActCopy();
    testMaj();
    testAndOr();
    testBadMaj();
    testNot();
    testBusyRefusal();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule